// File: doc/BRIEF.md
# Two-Step Coarse/Fine Conversion Sequencer

This block is the digital controller of one column of a two-step analog-to-digital converter. It shares one comparator between two phases. After a start request it opens a sampling window. It then runs a 7-bit successive-approximation search on a capacitor-DAC code, deciding the most significant bit first. Once that coarse code is fixed, it releases a ramp and counts clock cycles until the comparator changes state, which gives a 7-bit fine value for the residue. The two parts are joined into a 14-bit word, which is announced with a one-cycle strobe.

The analog side (DAC, ramp generator, comparator) lies outside the block. The controller drives the DAC code and the sample and ramp controls, and reads one comparator bit each clock. With the default settings a conversion takes at most 144 clock cycles, or 2.88 µs at a 50 MHz conversion clock. That is inside a 4.2 µs conversion slot.

Top module: `tsadc_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, busy_o, valid_o, sample_o, ramp_rst_o and ramp_en_o are 0, and data_o and dac_code_o are 0.
- R2: A start_i seen high at a clock edge while idle is accepted. sample_o is then high for exactly SAMPLE_CYC cycles, starting in the cycle after that edge, and busy_o rises in the same cycle.
- R3: The coarse search handles bits from MSB to LSB, two cycles per bit. In both cycles dac_code_o shows the bits already kept, with the trial bit set. At the second edge the trial bit is kept if cmp_i is 1 (input at or above the reference) and cleared if it is 0. The first trial code is therefore 64.
- R4: ramp_en_o stays low until all 7 coarse decisions are made. While ramp_en_o is high, dac_code_o holds the final coarse code and does not change.
- R5: The fine value is the number of ramp cycles in which cmp_i was 1 before the first ramp cycle in which cmp_i is 0. ramp_en_o drops after that cycle.
- R6: If cmp_i never falls, the fine count saturates at 127 and the ramp ends after 128 cycles.
- R7: data_o carries the coarse code in bits [13:7] and the fine count in bits [6:0].
- R8: valid_o is high for exactly one cycle per conversion, in the cycle where data_o first shows the new word. data_o holds its value until the next conversion completes.
- R9: start_i is ignored while busy_o is high. A conversion in flight is not restarted, and no extra conversion follows.
- R10: valid_o rises at the (SAMPLE_CYC + 15 + F)-th clock edge after the accepting edge, where F is the fine count. That is at most 144 edges with the defaults. In the cycle of valid_o, busy_o is already low.
- R11: ramp_rst_o is high throughout sampling and the coarse search and low otherwise. It is never high together with ramp_en_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, sampled each edge |
| cmp_i | input | 1 | Comparator result, 1 = input at or above reference |
| dac_code_o | output | 7 | Capacitor-DAC code |
| sample_o | output | 1 | Sampling switch control |
| ramp_rst_o | output | 1 | Holds the ramp discharged |
| ramp_en_o | output | 1 | Lets the ramp run |
| busy_o | output | 1 | Conversion in progress |
| valid_o | output | 1 | One-cycle result strobe |
| data_o | output | 14 | Merged coarse/fine result |

## Verification
The completion strobe and the acceptance of a new request can land in the same cycle. The sequencer is already idle while valid_o is high, so a start_i held high straight through the end of one conversion is taken on the very next edge. The bench keeps start_i asserted across that boundary and switches the modelled input voltage during the strobe cycle. It then expects busy_o to be high again one cycle later, the first word to remain on data_o, and the second conversion to report the new voltage. A separate case pulses start_i during the search and during the ramp. It expects one result and an idle block afterwards.

// File: rtl/tsadc_pkg.sv
package tsadc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SAMPLE,
        PH_TRIAL,
        PH_DECIDE,
        PH_RAMP
    } phase_e;

endpackage

// File: rtl/tsadc_sar_reg.sv
module tsadc_sar_reg #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init_i,
    input  logic         decide_i,
    input  logic         cmp_i,
    output logic [W-1:0] trial_o,
    output logic [W-1:0] code_o,
    output logic         last_o
);
    localparam logic [W-1:0] MSB_MASK = W'(1) << (W - 1);

    typedef struct packed {
        logic [W-1:0] code;
        logic [W-1:0] mask;
    } sar_s;

    sar_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (init_i) begin
            r_d.code = '0;
            r_d.mask = MSB_MASK;
        end else if (decide_i) begin
            if (cmp_i) begin
                r_d.code = r_q.code | r_q.mask;
            end
            r_d.mask = r_q.mask >> 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign trial_o = r_q.code | r_q.mask;
    assign code_o  = r_q.code;
    assign last_o  = r_q.mask[0];

    // R3: the pointer walks as a single bit, never two at once
    p_mask_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(r_q.mask));

    // R3: the bit under trial ends up equal to the comparator reading
    p_keep_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        decide_i |=> (((r_q.code & $past(r_q.mask)) != '0) == $past(cmp_i)));

endmodule

// File: rtl/tsadc_fine_cnt.sv
module tsadc_fine_cnt #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         run_i,
    input  logic         cmp_i,
    output logic [W-1:0] count_o,
    output logic         done_o
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] count;
    } cnt_s;

    cnt_s r_d, r_q;
    logic at_max;
    logic stop;

    always_comb begin
        at_max = (r_q.count == CNT_MAX);
        stop   = run_i && (!cmp_i || at_max);
        r_d    = r_q;
        if (clear_i) begin
            r_d.count = '0;
        end else if (run_i && !stop) begin
            r_d.count = r_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign count_o = r_q.count;
    assign done_o  = stop;

    // R6: once the ramp ends, the count freezes
    p_count_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (r_q.count == $past(r_q.count)));

    // R5: while running and not finished the count moves up by one
    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !done_o && !clear_i) |=> (r_q.count == $past(r_q.count) + 1'b1));

endmodule

// File: rtl/tsadc_seq.sv
module tsadc_seq
    import tsadc_pkg::*;
#(
    parameter int SAMPLE_CYC = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start_i,
    input  logic   sar_last_i,
    input  logic   fine_done_i,
    output phase_e phase_o,
    output logic   accept_o
);
    localparam int SMP_W = (SAMPLE_CYC > 1) ? $clog2(SAMPLE_CYC) : 1;
    localparam logic [SMP_W-1:0] SMP_LAST = SMP_W'(SAMPLE_CYC - 1);

    typedef struct packed {
        phase_e           ph;
        logic [SMP_W-1:0] smp;
    } seq_s;

    seq_s r_d, r_q;

    always_comb begin
        r_d      = r_q;
        accept_o = 1'b0;
        unique case (r_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    accept_o = 1'b1;
                    r_d.ph   = PH_SAMPLE;
                    r_d.smp  = '0;
                end
            end
            PH_SAMPLE: begin
                if (r_q.smp == SMP_LAST) begin
                    r_d.ph = PH_TRIAL;
                end else begin
                    r_d.smp = r_q.smp + 1'b1;
                end
            end
            PH_TRIAL: begin
                r_d.ph = PH_DECIDE;
            end
            PH_DECIDE: begin
                r_d.ph = sar_last_i ? PH_RAMP : PH_TRIAL;
            end
            PH_RAMP: begin
                if (fine_done_i) begin
                    r_d.ph = PH_IDLE;
                end
            end
            default: begin
                r_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{ph: PH_IDLE, smp: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign phase_o = r_q.ph;

    // R2: the sampling window is not cut short
    p_sample_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph == PH_SAMPLE && r_q.smp != SMP_LAST) |=> (r_q.ph == PH_SAMPLE));

    // R9: a request during the search does not reopen sampling
    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph != PH_IDLE && start_i) |=> (r_q.ph != PH_SAMPLE || $past(r_q.ph) == PH_SAMPLE));

    // R4: the ramp is only entered from the last coarse decision
    p_ramp_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph == PH_RAMP && $past(r_q.ph) != PH_RAMP) |-> ($past(r_q.ph) == PH_DECIDE && $past(sar_last_i)));

endmodule

// File: rtl/tsadc_ctrl.sv
module tsadc_ctrl
    import tsadc_pkg::*;
#(
    parameter int COARSE_W   = 7,
    parameter int FINE_W     = 7,
    parameter int SAMPLE_CYC = 2,
    localparam int RES_W     = COARSE_W + FINE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                cmp_i,
    output logic [COARSE_W-1:0] dac_code_o,
    output logic                sample_o,
    output logic                ramp_rst_o,
    output logic                ramp_en_o,
    output logic                busy_o,
    output logic                valid_o,
    output logic [RES_W-1:0]    data_o
);
    phase_e              phase;
    logic                accept;
    logic [COARSE_W-1:0] sar_trial;
    logic [COARSE_W-1:0] sar_code;
    logic                sar_last;
    logic [FINE_W-1:0]   fine_count;
    logic                fine_done;
    logic                in_search;

    typedef struct packed {
        logic [RES_W-1:0] data;
        logic             valid;
    } res_s;

    res_s r_d, r_q;

    tsadc_seq #(
        .SAMPLE_CYC (SAMPLE_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .sar_last_i  (sar_last),
        .fine_done_i (fine_done),
        .phase_o     (phase),
        .accept_o    (accept)
    );

    tsadc_sar_reg #(
        .W (COARSE_W)
    ) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_i   (accept),
        .decide_i (phase == PH_DECIDE),
        .cmp_i    (cmp_i),
        .trial_o  (sar_trial),
        .code_o   (sar_code),
        .last_o   (sar_last)
    );

    tsadc_fine_cnt #(
        .W (FINE_W)
    ) u_fine (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .run_i   (phase == PH_RAMP),
        .cmp_i   (cmp_i),
        .count_o (fine_count),
        .done_o  (fine_done)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        if (fine_done) begin
            r_d.data  = {sar_code, fine_count};
            r_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_search  = (phase == PH_TRIAL) || (phase == PH_DECIDE);
    assign dac_code_o = in_search ? sar_trial : sar_code;
    assign sample_o   = (phase == PH_SAMPLE);
    assign ramp_rst_o = (phase == PH_SAMPLE) || in_search;
    assign ramp_en_o  = (phase == PH_RAMP);
    assign busy_o     = (phase != PH_IDLE);
    assign valid_o    = r_q.valid;
    assign data_o     = r_q.data;

    // R8: the strobe lasts a single cycle
    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R8: the word only changes together with the strobe
    p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(data_o));

    // R4: the DAC code is frozen while the ramp runs
    p_dac_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_en_o && $past(ramp_en_o)) |-> $stable(dac_code_o));

    // R11: ramp discharge and ramp run never overlap
    p_ramp_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(ramp_en_o && (ramp_rst_o || sample_o)));

    // R9: busy only rises in answer to a request
    p_busy_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R10: the block is idle when the strobe appears
    p_idle_at_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !busy_o);

endmodule

// File: tb/tsadc_ctrl_test.sv
module tsadc_ctrl_test;
    localparam int SMP   = 2;
    localparam int VEC_N = 11;
    localparam int VIN [VEC_N] = '{0, 1, 127, 128, 255, 5000, 8191, 8192, 12345, 16383, 20000};
    localparam int EXPV[VEC_N] = '{0, 1, 127, 128, 255, 5000, 8191, 8192, 12345, 16383, 16383};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        cmp_i;
    logic [6:0]  dac_code_o;
    logic        sample_o, ramp_rst_o, ramp_en_o, busy_o, valid_o;
    logic [13:0] data_o;

    int vin = 0;
    int k_tb = 0;
    bit stuck_en = 1'b0;
    bit stuck_val = 1'b0;
    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    tsadc_ctrl #(.SAMPLE_CYC(SMP)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .cmp_i      (cmp_i),
        .dac_code_o (dac_code_o),
        .sample_o   (sample_o),
        .ramp_rst_o (ramp_rst_o),
        .ramp_en_o  (ramp_en_o),
        .busy_o     (busy_o),
        .valid_o    (valid_o),
        .data_o     (data_o)
    );

    // behavioural analog: DAC step of 128 fine LSBs, ramp one LSB per cycle
    always @(negedge clk) k_tb <= ramp_en_o ? k_tb + 1 : 0;
    assign cmp_i = stuck_en ? stuck_val :
                   ramp_en_o ? (vin >= int'(dac_code_o) * 128 + k_tb) :
                               (vin >= int'(dac_code_o) * 128);

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic convert(input int expw);
        int n = 0;
        int f = expw & 127;
        int bad_smp = 0;
        int bad_ramp = 0;
        int dac_first = -1;
        bit done = 1'b0;
        start_i = 1'b1;
        while (!done && n < 300) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            start_i = 1'b0;
            if (sample_o != (n <= SMP)) bad_smp++;
            if (ramp_en_o != (n >= SMP + 15 && n <= SMP + 15 + f)) bad_ramp++;
            if (n == SMP + 1) dac_first = int'(dac_code_o);
            if (valid_o) done = 1'b1;
        end
        chk(data_o == 14'(expw), "R7 result word", int'(data_o), expw);
        chk(n == SMP + 16 + f, "R10 latency", n - 1, SMP + 15 + f);
        chk(bad_smp == 0, "R2 sample window", bad_smp, 0);
        chk(bad_ramp == 0, "R4 R5 ramp window", bad_ramp, 0);
        chk(dac_first == 64, "R3 first trial code", dac_first, 64);
        chk(!busy_o, "R10 idle at strobe", int'(busy_o), 0);
        @(negedge clk);
        chk(!valid_o && data_o == 14'(expw), "R8 pulse and hold", int'(valid_o), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy_o && !valid_o && !sample_o && !ramp_en_o && !ramp_rst_o, "R1 reset controls", 1, 0);
        chk(data_o == '0 && dac_code_o == '0, "R1 reset data", int'(data_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && data_o == '0 && dac_code_o == '0, "R1 after release", int'(busy_o), 0);

        for (int i = 0; i < VEC_N; i++) begin
            vin = VIN[i];
            convert(EXPV[i]);
            repeat (2) @(negedge clk);
        end

        // R6: comparator stuck high -> coarse all ones, fine saturates
        stuck_en = 1'b1; stuck_val = 1'b1;
        convert(16383);
        // R5: comparator stuck low -> fine of zero after one ramp cycle
        stuck_val = 1'b0;
        convert(0);
        stuck_en = 1'b0;

        // R9: requests during search and ramp are ignored
        vin = 9000;
        start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (8) @(negedge clk);
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        repeat (20) @(negedge clk);
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        for (int c = 0; c < 300 && !valid_o; c++) @(negedge clk);
        chk(valid_o && data_o == 14'd9000, "R9 single result", int'(data_o), 9000);
        repeat (5) @(negedge clk);
        chk(!busy_o && !valid_o, "R9 no extra conversion", int'(busy_o), 0);

        // strobe and new acceptance in the same cycle
        vin = 3000;
        start_i = 1'b1;
        for (int c = 0; c < 300 && !valid_o; c++) @(negedge clk);
        vin = 14000;
        chk(data_o == 14'd3000, "R8 first of pair", int'(data_o), 3000);
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o && data_o == 14'd3000, "R2 accept in strobe cycle", int'(busy_o), 1);
        for (int c = 0; c < 300 && !valid_o; c++) @(negedge clk);
        chk(data_o == 14'd14000, "R7 second of pair", int'(data_o), 14000);
        chk(!ramp_rst_o && !ramp_en_o, "R11 idle ramp controls", int'(ramp_rst_o), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule